// File: doc/BRIEF.md
# Debug-Mode CSR and Entry Unit

This unit lives inside a processor core and holds the state that belongs to debug mode: the debug control/status register, the saved debug PC and one scratch data register that the external debug module exchanges values through. It decides when the core stops, what it records about why it stopped, and where execution resumes once the debugger lets it go.

The pipeline reports two kinds of halt cause. A synchronous cause (an exception, an `ebreak`, or a trigger match) arrives with the PC of the instruction that caused it. An asynchronous halt request arrives with the PC of the next instruction that has not executed yet. Either one halts the core, saves the PC in the debug PC register and records a cause code. A resume request clears the halted state and presents the saved PC to the fetch unit for one cycle. While the core is halted, the CSR port reads and writes the three registers. The debug module also has a private path that writes and reads the scratch register directly.

Several control/status fields are fixed. Interrupts are never enabled during single step. Counters and the timer always stop in debug mode. The privilege field always reads machine mode, so every resume returns to machine mode.

Top module: `dbg_csr_unit`

## Requirements
- R1: After reset the unit is running (`halted`=0, `resumeValid`=0), the control/status register reads 0x40000603, and the debug PC and scratch registers read 0.
- R2: A synchronous cause seen while running sets `halted` at the next clock edge and saves `syncPc` in the debug PC. Cause code 2 is recorded for `syncCause`=2 (trigger). Cause code 1 is recorded for every other `syncCause` value (0 exception, 1 ebreak, 3 treated as exception).
- R3: A halt request seen while running, with no synchronous cause, sets `halted` at the next edge, saves `nextPc` and records cause code 3.
- R4: When a synchronous cause and a halt request arrive in the same cycle, the synchronous one wins: its PC and its cause code are recorded.
- R5: Synchronous causes and halt requests that arrive while halted are ignored. The debug PC and the cause field keep their values.
- R6: A resume request while halted clears `halted` at the next edge. In that same cycle `resumeValid` is high for exactly one cycle with `resumePc` equal to the saved debug PC. A resume request while running has no effect.
- R7: The control/status register at address 0x7b0 reads with these fields: debug version 4 in bits 31:28, a writable breakpoint-enter-debug bit in bit 15, step-interrupt-enable 0 in bit 11, stop-count 1 in bit 10, stop-time 1 in bit 9, cause in bits 8:6, a writable step bit in bit 2, and privilege 3 in bits 1:0. All other bits read 0. Writes change only bits 15 and 2.
- R8: The debug PC at 0x7b1 and the scratch register at 0x7b2 are fully readable and writable. `csrHit` is 1 only for an enabled access to 0x7b0 to 0x7b2. Any other address reads 0 with `csrHit`=0.
- R9: A debug-module write to the scratch register is seen on both read paths. When it coincides with a core CSR write to the same register, the debug-module value is kept.
- R10: A halt entry in the same cycle as a core CSR write to the debug PC keeps the entry PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| syncValid | input | 1 | Synchronous debug cause this cycle |
| syncCause | input | 2 | 0 exception, 1 ebreak, 2 trigger |
| syncPc | input | 32 | PC of the causing instruction |
| haltReq | input | 1 | External halt request |
| nextPc | input | 32 | PC of the next unexecuted instruction |
| resumeReq | input | 1 | Request to leave debug mode |
| csrEn | input | 1 | CSR access valid |
| csrWen | input | 1 | CSR access is a write |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | 32 | CSR write data |
| csrRdata | output | 32 | CSR read data (combinational) |
| csrHit | output | 1 | Address belongs to this unit |
| dmData0Wen | input | 1 | Debug-module write of scratch register |
| dmData0Wdata | input | 32 | Debug-module write data |
| dmData0Rdata | output | 32 | Scratch register value for the debug module |
| halted | output | 1 | Core is in debug mode |
| resumeValid | output | 1 | One-cycle pulse: redirect fetch to resumePc |
| resumePc | output | 32 | Saved debug PC |

## Verification
A wrong cause or PC capture shows at the ports only as the values read back through the CSR port after the core halts. It therefore appears in the cycle after entry, at the first read, and the bench reads after every entry. A wrong halted flag appears one edge after the request, as a missing or extra `resumeValid` pulse or a stuck `halted`. A hardwired field that became writable shows up only after a write that touches it, so every bit of the control/status register is written in turn and read back at once.

// File: rtl/dbg_csr_pkg.sv
package dbg_csr_pkg;
  localparam int XLEN = 32;
  localparam int CSR_AW = 12;
  localparam logic [CSR_AW-1:0] ADDR_DCTL = 12'h7b0;
  localparam logic [CSR_AW-1:0] ADDR_DPC = 12'h7b1;
  localparam logic [CSR_AW-1:0] ADDR_SCR = 12'h7b2;
  localparam int NUM_REGS = 3;

  localparam logic [2:0] CAUSE_BRK = 3'd1;
  localparam logic [2:0] CAUSE_TRIG = 3'd2;
  localparam logic [2:0] CAUSE_HALT = 3'd3;

  localparam logic [1:0] SYNC_TRIGGER = 2'd2;

  typedef struct packed {
    logic entry;
    logic fromSync;
    logic [2:0] cause;
    logic resume;
    logic dctlWen;
    logic dpcWen;
    logic scrWen;
    logic dmScrWen;
  } dbgStrobesT;
endpackage

// File: rtl/dbg_csr_ctrl.sv
module dbg_csr_ctrl
  import dbg_csr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic syncValid,
  input  logic [1:0] syncCause,
  input  logic haltReq,
  input  logic resumeReq,
  input  logic csrEn,
  input  logic csrWen,
  input  logic [CSR_AW-1:0] csrAddr,
  input  logic dmData0Wen,
  output dbgStrobesT strb,
  output logic [NUM_REGS-1:0] regSel,
  output logic halted,
  output logic resumeValid
);
  logic haltedQ;
  logic resumeValidQ;
  logic entryReq;
  logic resumeFire;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign regSel[i] = csrEn && (csrAddr == ADDR_DCTL + CSR_AW'(i));
  end

  assign entryReq = !haltedQ && (syncValid || haltReq);
  assign resumeFire = haltedQ && resumeReq;

  always_comb begin
    strb = '0;
    strb.entry = entryReq;
    strb.fromSync = syncValid;
    if (syncValid) begin
      strb.cause = (syncCause == SYNC_TRIGGER) ? CAUSE_TRIG : CAUSE_BRK;
    end else begin
      strb.cause = CAUSE_HALT;
    end
    strb.resume = resumeFire;
    strb.dctlWen = csrWen && regSel[0];
    strb.dpcWen = csrWen && regSel[1];
    strb.scrWen = csrWen && regSel[2];
    strb.dmScrWen = dmData0Wen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltedQ <= 1'b0;
      resumeValidQ <= 1'b0;
    end else begin
      resumeValidQ <= resumeFire;
      if (entryReq) begin
        haltedQ <= 1'b1;
      end else if (resumeFire) begin
        haltedQ <= 1'b0;
      end
    end
  end

  assign halted = haltedQ;
  assign resumeValid = resumeValidQ;

  AST_ENTRY_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && (syncValid || haltReq)) |=> halted); // R2
  AST_HALTED_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !resumeReq) |=> halted); // R5
  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (halted && resumeReq) |=> (!halted && resumeValid)); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |=> !resumeValid); // R6
endmodule

// File: rtl/dbg_csr_datapath.sv
module dbg_csr_datapath
  import dbg_csr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  dbgStrobesT strb,
  input  logic [NUM_REGS-1:0] regSel,
  input  logic [XLEN-1:0] syncPc,
  input  logic [XLEN-1:0] nextPc,
  input  logic [XLEN-1:0] csrWdata,
  input  logic [XLEN-1:0] dmData0Wdata,
  output logic [XLEN-1:0] csrRdata,
  output logic [XLEN-1:0] scrValue,
  output logic [XLEN-1:0] dpcValue,
  output logic [2:0] causeValue
);
  localparam int BIT_BRKM = 15;
  localparam int BIT_STEP = 2;
  localparam logic [3:0] DBG_VERSION = 4'd4;

  logic brkEnterQ;
  logic stepQ;
  logic [2:0] causeQ;
  logic [XLEN-1:0] dpcQ;
  logic [XLEN-1:0] scrQ;
  logic [XLEN-1:0] dctlView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkEnterQ <= 1'b0;
      stepQ <= 1'b0;
      causeQ <= 3'd0;
    end else begin
      if (strb.entry) begin
        causeQ <= strb.cause;
      end
      if (strb.dctlWen) begin
        brkEnterQ <= csrWdata[BIT_BRKM];
        stepQ <= csrWdata[BIT_STEP];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpcQ <= '0;
    end else if (strb.entry) begin
      dpcQ <= strb.fromSync ? syncPc : nextPc;
    end else if (strb.dpcWen) begin
      dpcQ <= csrWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scrQ <= '0;
    end else if (strb.dmScrWen) begin
      scrQ <= dmData0Wdata;
    end else if (strb.scrWen) begin
      scrQ <= csrWdata;
    end
  end

  always_comb begin
    dctlView = '0;
    dctlView[31:28] = DBG_VERSION;
    dctlView[BIT_BRKM] = brkEnterQ;
    dctlView[11] = 1'b0;
    dctlView[10] = 1'b1;
    dctlView[9] = 1'b1;
    dctlView[8:6] = causeQ;
    dctlView[BIT_STEP] = stepQ;
    dctlView[1:0] = 2'b11;
  end

  always_comb begin
    csrRdata = '0;
    unique case (1'b1)
      regSel[0]: csrRdata = dctlView;
      regSel[1]: csrRdata = dpcQ;
      regSel[2]: csrRdata = scrQ;
      default: csrRdata = '0;
    endcase
  end

  assign scrValue = scrQ;
  assign dpcValue = dpcQ;
  assign causeValue = causeQ;

  AST_DPC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.entry && !strb.dpcWen) |=> $stable(dpcQ)); // R5
  AST_DM_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.dmScrWen |=> (scrQ == $past(dmData0Wdata))); // R9
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regSel)); // R8
endmodule

// File: rtl/dbg_csr_unit.sv
module dbg_csr_unit
  import dbg_csr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic syncValid,
  input  logic [1:0] syncCause,
  input  logic [31:0] syncPc,
  input  logic haltReq,
  input  logic [31:0] nextPc,
  input  logic resumeReq,
  input  logic csrEn,
  input  logic csrWen,
  input  logic [11:0] csrAddr,
  input  logic [31:0] csrWdata,
  output logic [31:0] csrRdata,
  output logic csrHit,
  input  logic dmData0Wen,
  input  logic [31:0] dmData0Wdata,
  output logic [31:0] dmData0Rdata,
  output logic halted,
  output logic resumeValid,
  output logic [31:0] resumePc
);
  dbgStrobesT strb;
  logic [NUM_REGS-1:0] regSel;
  logic [2:0] causeValue;

  dbg_csr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .syncValid(syncValid), .syncCause(syncCause),
    .haltReq(haltReq), .resumeReq(resumeReq), .csrEn(csrEn), .csrWen(csrWen),
    .csrAddr(csrAddr), .dmData0Wen(dmData0Wen), .strb(strb), .regSel(regSel),
    .halted(halted), .resumeValid(resumeValid)
  );

  dbg_csr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regSel(regSel), .syncPc(syncPc),
    .nextPc(nextPc), .csrWdata(csrWdata), .dmData0Wdata(dmData0Wdata),
    .csrRdata(csrRdata), .scrValue(dmData0Rdata), .dpcValue(resumePc),
    .causeValue(causeValue)
  );

  assign csrHit = |regSel;

  AST_HALT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (causeValue != 3'd0)); // R2
  AST_PULSE_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |-> !halted); // R6
endmodule

// File: tb/tb_dbg_csr_unit.sv
module tb_dbg_csr_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncValid = 0, haltReq = 0, resumeReq = 0;
  logic [1:0] syncCause = 0;
  logic [31:0] syncPc = 0, nextPc = 0, csrWdata = 0, dmData0Wdata = 0;
  logic csrEn = 0, csrWen = 0, dmData0Wen = 0;
  logic [11:0] csrAddr = 0;
  logic [31:0] csrRdata, dmData0Rdata, resumePc;
  logic csrHit, halted, resumeValid;
  int total = 0;
  int bad = 0;
  bit doneFlag = 0;

  always #10 clk = ~clk;

  dbg_csr_unit dut (.*);

  function automatic logic [31:0] expDctl(logic brk, logic stp, logic [2:0] cause);
    return 32'h4000_0603 | (32'(brk) << 15) | (32'(stp) << 2) | (32'(cause) << 6);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic csrWr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csrEn = 1; csrWen = 1; csrAddr = a; csrWdata = d;
    @(negedge clk);
    csrEn = 0; csrWen = 0;
  endtask

  task automatic csrRd(logic [11:0] a, output logic [31:0] d, output logic h);
    @(negedge clk);
    csrEn = 1; csrWen = 0; csrAddr = a;
    #1;
    d = csrRdata; h = csrHit;
    csrEn = 0;
  endtask

  task automatic resumeAndCheck(logic [31:0] expPc);
    @(negedge clk);
    resumeReq = 1;
    @(negedge clk);
    resumeReq = 0;
    #1;
    check("R6 halted cleared", 32'(halted), 0);
    check("R6 pulse high", 32'(resumeValid), 1);
    check("R6 resumePc", resumePc, expPc);
    @(negedge clk);
    #1;
    check("R6 pulse one cycle", 32'(resumeValid), 0);
  endtask

  task automatic finishUp();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin
    logic [31:0] d;
    logic h;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    check("R1 halted", 32'(halted), 0);
    check("R1 resumeValid", 32'(resumeValid), 0);
    csrRd(12'h7b0, d, h); check("R1 dctl", d, 32'h4000_0603);
    csrRd(12'h7b1, d, h); check("R1 dpc", d, 0);
    csrRd(12'h7b2, d, h); check("R1 scratch", d, 0);

    // R8 address sweep
    for (int a = 12'h7a0; a < 12'h7c0; a++) begin
      csrRd(12'(a), d, h);
      if (a >= 12'h7b0 && a <= 12'h7b2) begin
        check("R8 hit", 32'(h), 1);
      end else begin
        check("R8 miss", 32'(h), 0);
        check("R8 miss data", d, 0);
      end
    end

    // R7 walking-one writes to control/status
    for (int b = 0; b < 32; b++) begin
      csrWr(12'h7b0, 32'h1 << b);
      csrRd(12'h7b0, d, h);
      check("R7 dctl walk", d, expDctl(b == 15, b == 2, 3'd0));
    end
    csrWr(12'h7b0, 32'hffff_ffff);
    csrRd(12'h7b0, d, h); check("R7 dctl all ones", d, expDctl(1, 1, 0));
    csrWr(12'h7b0, 32'h0);

    // R8 read/write patterns
    for (int k = 0; k < 8; k++) begin
      logic [31:0] p;
      p = 32'h1357_9bdf * (k + 1) ^ (32'hff << (k * 3));
      csrWr(12'h7b1, p);
      csrWr(12'h7b2, ~p);
      csrRd(12'h7b1, d, h); check("R8 dpc rw", d, p);
      csrRd(12'h7b2, d, h); check("R8 scratch rw", d, ~p);
      check("R9 dm sees core write", dmData0Rdata, ~p);
    end

    // R2 synchronous entry for each cause, R5 ignored requests
    for (int c = 0; c < 4; c++) begin
      logic [31:0] pc;
      logic [2:0] expCause;
      pc = 32'h0000_1000 + 32'(c) * 32'h44;
      expCause = (c == 2) ? 3'd2 : 3'd1;
      @(negedge clk);
      syncValid = 1; syncCause = 2'(c); syncPc = pc;
      @(negedge clk);
      syncValid = 0;
      #1;
      check("R2 halted", 32'(halted), 1);
      csrRd(12'h7b0, d, h); check("R2 cause", d, expDctl(0, 0, expCause));
      csrRd(12'h7b1, d, h); check("R2 dpc", d, pc);
      @(negedge clk);
      haltReq = 1; nextPc = 32'hdead_0000; syncValid = 1; syncCause = 2'(c ^ 2); syncPc = 32'hbeef_0000;
      @(negedge clk);
      haltReq = 0; syncValid = 0;
      csrRd(12'h7b0, d, h); check("R5 cause kept", d, expDctl(0, 0, expCause));
      csrRd(12'h7b1, d, h); check("R5 dpc kept", d, pc);
      resumeAndCheck(pc);
    end

    // R3 halt request entry
    @(negedge clk);
    haltReq = 1; nextPc = 32'h0000_2468;
    @(negedge clk);
    haltReq = 0;
    #1;
    check("R3 halted", 32'(halted), 1);
    csrRd(12'h7b0, d, h); check("R3 cause", d, expDctl(0, 0, 3));
    csrRd(12'h7b1, d, h); check("R3 dpc", d, 32'h0000_2468);
    resumeAndCheck(32'h0000_2468);

    // R6 resume while running
    @(negedge clk);
    resumeReq = 1;
    @(negedge clk);
    resumeReq = 0;
    #1;
    check("R6 no pulse when running", 32'(resumeValid), 0);
    check("R6 still running", 32'(halted), 0);

    // R4 simultaneous causes
    @(negedge clk);
    haltReq = 1; nextPc = 32'h0000_3000; syncValid = 1; syncCause = 2; syncPc = 32'h0000_3ffc;
    @(negedge clk);
    haltReq = 0; syncValid = 0;
    csrRd(12'h7b0, d, h); check("R4 sync cause wins", d, expDctl(0, 0, 2));
    csrRd(12'h7b1, d, h); check("R4 sync pc wins", d, 32'h0000_3ffc);
    resumeAndCheck(32'h0000_3ffc);

    // R10 entry beats core write to dpc
    @(negedge clk);
    haltReq = 1; nextPc = 32'h0000_4444;
    csrEn = 1; csrWen = 1; csrAddr = 12'h7b1; csrWdata = 32'h5555_5555;
    @(negedge clk);
    haltReq = 0; csrEn = 0; csrWen = 0;
    csrRd(12'h7b1, d, h); check("R10 entry pc kept", d, 32'h0000_4444);
    resumeAndCheck(32'h0000_4444);

    // R9 debug-module path
    @(negedge clk);
    dmData0Wen = 1; dmData0Wdata = 32'hcafe_f00d;
    @(negedge clk);
    dmData0Wen = 0;
    #1;
    check("R9 dm readback", dmData0Rdata, 32'hcafe_f00d);
    csrRd(12'h7b2, d, h); check("R9 core sees dm write", d, 32'hcafe_f00d);
    @(negedge clk);
    dmData0Wen = 1; dmData0Wdata = 32'h0bad_cafe;
    csrEn = 1; csrWen = 1; csrAddr = 12'h7b2; csrWdata = 32'h1111_2222;
    @(negedge clk);
    dmData0Wen = 0; csrEn = 0; csrWen = 0;
    #1;
    check("R9 dm wins", dmData0Rdata, 32'h0bad_cafe);

    finishUp();
  end
endmodule